// File: doc/BRIEF.md
# Delay-Slot Branch Resolver and Fetch PC Unit

This unit owns the fetch program counter of a pipelined 64-bit processor in which every control transfer has exactly one architectural delay slot. Each cycle it is shown the transfer kind of the instruction fetched at the current PC. It also receives the two offset fields, a register operand and the negative and overflow flags. From these it decides whether the transfer is taken and what the target is.

The redirect is held in a register. The instruction at PC + 4 is therefore always fetched and executed as the delay slot, and the target becomes the fetch address one cycle after that. A call also asks for a single-cycle write of its return address into the link register. Instruction decoding, the register file and operand forwarding sit outside the unit.

The transfer kind is a 3-bit code: 0 none, 1 jump (long offset), 2 branch-if-less (short offset), 3 call (long offset plus link), 4 jump-to-register, 5 branch-if-zero (short offset). Codes 6 and 7 act as none. Offset targets are the PC plus the offset shifted left by two and sign-extended to 64 bits.

Top module: `pc_redirect_unit`

## Requirements
- R1: After a synchronous active-high reset, `pc` is 0, `taken` and `link_we` are low, and the next fetch is 4.
- R2: With no transfer, meaning code 0, 6 or 7, or `in_valid` low, `taken` is low and `next_pc` is `pc` + 4.
- R3: Code 1 is always taken, with target `pc` + sign-extended (`off_long` << 2). Both forward and backward offsets are covered.
- R4: Code 2 is taken exactly when `flag_n` differs from `flag_v`, with target `pc` + sign-extended (`off_short` << 2).
- R5: Code 3 is taken with the long-offset target. In that same cycle only, `link_we` is high, `link_idx` is 30 and `link_data` is `pc` + 4. `link_we` is low for every other code.
- R6: Code 4 is taken with a target equal to the full 64-bit `reg_val`.
- R7: Code 5 is taken only when `reg_val` is zero, with the short-offset target.
- R8: After any transfer at address P, the next fetch is P + 4, the delay slot. If the transfer was taken, the fetch after that is the target, and `next_pc` shows the target during the delay-slot cycle. If it was not taken, that fetch is P + 8.
- R9: A transfer code presented in a delay-slot cycle is ignored: `taken` and `link_we` stay low and the fetch sequence is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The instruction at `pc` is valid this cycle |
| br_kind | input | 3 | Transfer kind code |
| off_long | input | 26 | Long word offset |
| off_short | input | 19 | Short word offset |
| reg_val | input | 64 | Register operand (jump target or zero test) |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| pc | output | 64 | Current fetch address |
| next_pc | output | 64 | Fetch address for the next cycle |
| taken | output | 1 | The transfer at `pc` is taken |
| link_we | output | 1 | Link register write request |
| link_idx | output | 5 | Link register index (30) |
| link_data | output | 64 | Return address to write |

## Verification
The branch-if-less kind is driven with all four flag pairs. Two pairs must redirect and two must fall through, which separates a differ test from a plain negative-flag test. Branch-if-zero is tried with a zero and a non-zero operand. The long offset is given a forward value and a negative one, so a missing sign extension or a missing shift shows up as a wrong address. Each transfer is followed through two fetches, which distinguishes a correctly delayed redirect from an immediate redirect or one that arrives late. Transfer codes placed in delay slots, both after a taken transfer and after a fall-through, show whether the ignore rule holds.

// File: rtl/bru_pkg.sv
`timescale 1ns/1ps
package bru_pkg;
   typedef enum logic [2:0] {
      BK_NONE = 3'd0,
      BK_JUMP = 3'd1,
      BK_LT   = 3'd2,
      BK_CALL = 3'd3,
      BK_REG  = 3'd4,
      BK_CBZ  = 3'd5
   } br_kind_e;
endpackage

// File: rtl/bru_offset_tgt.sv
`timescale 1ns/1ps
module bru_offset_tgt #(
   parameter int XLEN  = 64,
   parameter int OFF_W = 26,
   parameter int SHIFT = 2
) (
   input  logic [XLEN-1:0]  base,
   input  logic [OFF_W-1:0] off,
   output logic [XLEN-1:0]  tgt
);
   localparam int EXT_W = XLEN - OFF_W - SHIFT;

   if (EXT_W < 1) begin : g_bad_width
      $error("bru_offset_tgt: offset plus shift must be narrower than XLEN");
   end
   if (SHIFT < 0) begin : g_bad_shift
      $error("bru_offset_tgt: SHIFT must not be negative");
   end

   if (SHIFT == 0) begin : g_noshift
      assign tgt = base + {{EXT_W{off[OFF_W-1]}}, off};
   end else begin : g_shift
      assign tgt = base + {{EXT_W{off[OFF_W-1]}}, off, {SHIFT{1'b0}}};
   end
endmodule

// File: rtl/bru_cond.sv
`timescale 1ns/1ps
module bru_cond
   import bru_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [2:0]      kind,
   input  logic [XLEN-1:0] reg_val,
   input  logic            flag_n,
   input  logic            flag_v,
   output logic            is_xfer,
   output logic            cond_met
);
   always_comb begin
      is_xfer  = 1'b1;
      cond_met = 1'b0;
      case (kind)
         BK_JUMP, BK_CALL, BK_REG: cond_met = 1'b1;
         BK_LT:                    cond_met = flag_n ^ flag_v;
         BK_CBZ:                   cond_met = (reg_val == '0);
         default:                  is_xfer  = 1'b0;
      endcase
   end
endmodule

// File: rtl/pc_redirect_unit.sv
`timescale 1ns/1ps
module pc_redirect_unit
   import bru_pkg::*;
#(
   parameter int XLEN     = 64,
   parameter int LONG_W   = 26,
   parameter int SHORT_W  = 19,
   parameter int ALIGN_SH = 2,
   parameter int IDX_W    = 5,
   parameter int LINK_IDX = 30,
   parameter int STEP     = 4,
   parameter logic [XLEN-1:0] RESET_PC = '0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               in_valid,
   input  logic [2:0]         br_kind,
   input  logic [LONG_W-1:0]  off_long,
   input  logic [SHORT_W-1:0] off_short,
   input  logic [XLEN-1:0]    reg_val,
   input  logic               flag_n,
   input  logic               flag_v,
   output logic [XLEN-1:0]    pc,
   output logic [XLEN-1:0]    next_pc,
   output logic               taken,
   output logic               link_we,
   output logic [IDX_W-1:0]   link_idx,
   output logic [XLEN-1:0]    link_data
);
   localparam logic [XLEN-1:0]  STEP_V = XLEN'(STEP);
   localparam logic [IDX_W-1:0] LINK_V = IDX_W'(LINK_IDX);

   if (LINK_IDX >= (1 << IDX_W)) begin : g_bad_link
      $error("pc_redirect_unit: LINK_IDX does not fit in IDX_W bits");
   end
   if (STEP < 1) begin : g_bad_step
      $error("pc_redirect_unit: STEP must be positive");
   end

   logic [XLEN-1:0] pc_q, pend_q, seq_pc, tgt_long, tgt_short, tgt_sel;
   logic            slot_q, redir_q, is_xfer, cond_met, live;

   bru_offset_tgt #(.XLEN(XLEN), .OFF_W(LONG_W), .SHIFT(ALIGN_SH)) u_long (
      .base(pc_q), .off(off_long), .tgt(tgt_long)
   );
   bru_offset_tgt #(.XLEN(XLEN), .OFF_W(SHORT_W), .SHIFT(ALIGN_SH)) u_short (
      .base(pc_q), .off(off_short), .tgt(tgt_short)
   );
   bru_cond #(.XLEN(XLEN)) u_cond (
      .kind(br_kind), .reg_val(reg_val), .flag_n(flag_n), .flag_v(flag_v),
      .is_xfer(is_xfer), .cond_met(cond_met)
   );

   assign seq_pc = pc_q + STEP_V;
   assign live   = in_valid & ~slot_q;
   assign taken  = live & cond_met;

   always_comb begin
      case (br_kind)
         BK_JUMP, BK_CALL: tgt_sel = tgt_long;
         BK_LT, BK_CBZ:    tgt_sel = tgt_short;
         BK_REG:           tgt_sel = reg_val;
         default:          tgt_sel = seq_pc;
      endcase
   end

   assign next_pc   = redir_q ? pend_q : seq_pc;
   assign pc        = pc_q;
   assign link_we   = live & (br_kind == BK_CALL);
   assign link_idx  = LINK_V;
   assign link_data = seq_pc;

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q    <= RESET_PC;
         pend_q  <= RESET_PC;
         slot_q  <= 1'b0;
         redir_q <= 1'b0;
      end else begin
         pc_q    <= next_pc;
         slot_q  <= live & is_xfer;
         redir_q <= taken;
         if (taken) pend_q <= tgt_sel;
      end
   end

   // R1
   reset_state_chk: assert property (@(posedge clk) rst |=> (pc == RESET_PC));

   // R8
   slot_fetch_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && is_xfer && !slot_q) |=> (pc == $past(pc) + STEP_V));

   // R8
   redirect_chk: assert property (@(posedge clk) disable iff (rst)
      taken |=> ##1 (pc == $past(tgt_sel, 2)));

   // R9
   slot_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      $past(taken) |-> (!taken && !link_we));

   // R5
   link_taken_chk: assert property (@(posedge clk) disable iff (rst)
      link_we |-> (taken && link_idx == LINK_V));
endmodule

// File: tb/tb_pc_redirect_unit.sv
`timescale 1ns/1ps
module tb_pc_redirect_unit;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [2:0]  br_kind = 3'd0;
   logic [25:0] off_long = '0;
   logic [18:0] off_short = '0;
   logic [63:0] reg_val = '0;
   logic        flag_n = 1'b0, flag_v = 1'b0;
   logic [63:0] pc, next_pc, link_data;
   logic        taken, link_we;
   logic [4:0]  link_idx;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #2 clk = ~clk;

   pc_redirect_unit dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .br_kind(br_kind),
      .off_long(off_long), .off_short(off_short), .reg_val(reg_val),
      .flag_n(flag_n), .flag_v(flag_v), .pc(pc), .next_pc(next_pc),
      .taken(taken), .link_we(link_we), .link_idx(link_idx), .link_data(link_data)
   );

   task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic drive(logic v, logic [2:0] k, logic [25:0] ol, logic [18:0] os,
                        logic [63:0] rv, logic n, logic ov);
      in_valid = v; br_kind = k; off_long = ol; off_short = os;
      reg_val = rv; flag_n = n; flag_v = ov;
   endtask

   function automatic logic [63:0] sx_long(logic [63:0] p, logic [25:0] o);
      return p + {{36{o[25]}}, o, 2'b00};
   endfunction
   function automatic logic [63:0] sx_short(logic [63:0] p, logic [18:0] o);
      return p + {{43{o[18]}}, o, 2'b00};
   endfunction

   // tsel: 0 long offset, 1 short offset, 2 register
   task automatic branch_case(string tag, logic [2:0] k, logic [25:0] ol, logic [18:0] os,
                              logic [63:0] rv, logic n, logic ov, bit exp_take,
                              int tsel, bit exp_link,
                              logic [2:0] slot_k = 3'd0, bit slot_v = 1'b0);
      logic [63:0] p, tgt, after;
      @(negedge clk);
      p = pc;
      drive(1'b1, k, ol, os, rv, n, ov);
      #1;
      tgt = (tsel == 0) ? sx_long(p, ol) : (tsel == 1) ? sx_short(p, os) : rv;
      after = exp_take ? tgt : p + 64'd8;
      chk({tag, " taken"}, 64'(taken), 64'(exp_take));
      chk({tag, " link_we"}, 64'(link_we), 64'(exp_link));
      if (exp_link) begin
         chk({tag, " link_idx"}, 64'(link_idx), 64'd30);
         chk({tag, " link_data"}, link_data, p + 64'd4);
      end
      chk({tag, " next_pc"}, next_pc, p + 64'd4);
      @(negedge clk);
      drive(slot_v, slot_k, 26'h0000123, 19'h00045, 64'd0, 1'b1, 1'b0);
      #1;
      chk({tag, " R8 slot pc"}, pc, p + 64'd4);
      chk({tag, " R8 slot next_pc"}, next_pc, after);
      chk({tag, " R9 slot taken"}, 64'(taken), 64'd0);
      chk({tag, " R9 slot link_we"}, 64'(link_we), 64'd0);
      @(negedge clk);
      drive(1'b0, 3'd0, '0, '0, '0, 1'b0, 1'b0);
      #1;
      chk({tag, " R8 final pc"}, pc, after);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      chk("R1 pc", pc, 64'd0);
      chk("R1 taken", 64'(taken), 64'd0);
      chk("R1 link_we", 64'(link_we), 64'd0);
      chk("R1 next_pc", next_pc, 64'd4);
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic t_sequential();
      logic [63:0] p;
      @(negedge clk);
      p = pc;
      drive(1'b1, 3'd0, '0, '0, '0, 1'b1, 1'b0);
      #1;
      chk("R2 none taken", 64'(taken), 64'd0);
      chk("R2 none next_pc", next_pc, p + 64'd4);
      @(negedge clk);
      #1;
      chk("R2 none pc", pc, p + 64'd4);
      for (int c = 6; c < 8; c++) begin
         drive(1'b1, 3'(c), 26'h0000040, 19'h00010, '0, 1'b1, 1'b0);
         #1;
         chk("R2 spare code taken", 64'(taken), 64'd0);
         chk("R2 spare code link", 64'(link_we), 64'd0);
         @(negedge clk);
      end
      p = pc;
      drive(1'b0, 3'd1, 26'h0000040, '0, '0, 1'b0, 1'b0);
      #1;
      chk("R2 invalid jump taken", 64'(taken), 64'd0);
      chk("R2 invalid jump next_pc", next_pc, p + 64'd4);
      @(negedge clk);
      drive(1'b0, 3'd0, '0, '0, '0, 1'b0, 1'b0);
      #1;
      chk("R2 invalid jump pc", pc, p + 64'd4);
   endtask

   task automatic t_jump();
      branch_case("R3 fwd", 3'd1, 26'h0000040, '0, '0, 0, 0, 1, 0, 0);
      branch_case("R3 back", 3'd1, 26'h3FFFFFD, '0, '0, 0, 0, 1, 0, 0);
   endtask

   task automatic t_less();
      branch_case("R4 n0v0", 3'd2, '0, 19'h00008, '0, 0, 0, 0, 1, 0);
      branch_case("R4 n1v0", 3'd2, '0, 19'h00008, '0, 1, 0, 1, 1, 0);
      branch_case("R4 n0v1", 3'd2, '0, 19'h7FFFF, '0, 0, 1, 1, 1, 0);
      branch_case("R4 n1v1", 3'd2, '0, 19'h00008, '0, 1, 1, 0, 1, 0);
   endtask

   task automatic t_call();
      branch_case("R5 call", 3'd3, 26'h0000010, '0, '0, 0, 0, 1, 0, 1);
   endtask

   task automatic t_reg();
      branch_case("R6 reg", 3'd4, '0, '0, 64'hDEAD_BEEF_0000_1230, 0, 0, 1, 2, 0);
   endtask

   task automatic t_cbz();
      branch_case("R7 zero", 3'd5, '0, 19'h00005, 64'd0, 0, 0, 1, 1, 0);
      branch_case("R7 nonzero", 3'd5, '0, 19'h00005, 64'd1, 0, 0, 0, 1, 0);
   endtask

   task automatic t_slot();
      // R9: call in the slot of a taken jump, then jump in the slot of a fall-through
      branch_case("R9 call-in-slot", 3'd1, 26'h0000020, '0, '0, 0, 0, 1, 0, 0, 3'd3, 1'b1);
      branch_case("R9 jump-in-slot", 3'd5, '0, 19'h00009, 64'd7, 0, 0, 0, 1, 0, 3'd1, 1'b1);
   endtask

   initial begin
      t_reset();
      t_sequential();
      t_jump();
      t_less();
      t_call();
      t_reg();
      t_cbz();
      t_slot();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule